// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the arithmetic condition flags of a 32-bit integer datapath and holds them in a 32-bit flags word with a fixed bit layout. Each cycle it receives the two source operands, the result already produced by the ALU, an operation class (add, subtract or logic), an operand width (byte, halfword or word) and an update strobe. When the strobe is high, the carry, parity, auxiliary carry, zero, sign and overflow bits are recomputed at the selected width and stored on the next rising clock edge.

The same word also holds a set of control and system bits: trap, interrupt enable, direction, a two-bit privilege level, nested task, resume and virtual mode. These bits are written only through a separate load port. The block stores them and does nothing else with them. Bits with no assigned meaning always read back at fixed values. The flags word is a register output, so a consumer sees the effect of an update one cycle after the strobe.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-high reset sets `flags_q` to 0x00000002 on the next rising edge.
- R2: When `upd_en` and `ctl_load` are both low, `flags_q` keeps its value, whatever the operand, result and class inputs are.
- R3: Carry (bit 0) is the carry out of the top bit of the selected width on an add (`op_class`=0). It is the borrow into that bit on a subtract (`op_class`=1). The top bit is bit 7, 15 or 31 for `op_size` 0, 1 or 2.
- R4: Overflow (bit 11) is set on an add or subtract when the signed result does not fit in the selected width, and is cleared otherwise.
- R5: Auxiliary carry (bit 4) is set on an add or subtract when there is a carry from bit 3 into bit 4, or a borrow from bit 4 into bit 3. It is cleared otherwise.
- R6: Parity (bit 2) is set when bits 7:0 of the result hold an even number of ones, at every operand width.
- R7: Zero (bit 6) is set when the result bits within the selected width are all zero. Result bits above the width are ignored. Sign (bit 7) copies the top bit of the selected width.
- R8: For a logic operation (`op_class` 2 or 3), carry and overflow are cleared and auxiliary carry keeps its previous value. Sign, zero and parity are computed as usual.
- R9: `ctl_load` writes `ctl_data` bits 8, 9, 10, 13:12, 14, 16 and 17 into the same positions and leaves the six arithmetic flags unchanged. An arithmetic update leaves those control bits unchanged. Both may happen in the same cycle.
- R10: Bit 1 always reads 1. Bits 3, 5, 15 and 31:18 always read 0, even when `ctl_data` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Store the arithmetic flags computed from this cycle's inputs |
| op_class | input | 2 | 0 add, 1 subtract, 2 or 3 logic |
| op_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| src_a | input | 32 | First operand (minuend on subtract) |
| src_b | input | 32 | Second operand (subtrahend on subtract) |
| result | input | 32 | ALU result for the operation |
| ctl_load | input | 1 | Write the control and system bits from `ctl_data` |
| ctl_data | input | 32 | New control and system bits, in the same layout as the flags word |
| flags_q | output | 32 | Registered flags word |

## Verification
A wrong carry, overflow or zero/sign decision inside the block shows up in `flags_q` one edge after the update strobe. Picking the wrong width lane gives a visibly different word as soon as the upper result bits disagree with the selected slice. A corrupted held auxiliary carry only becomes visible after a later logic operation, because that bit is carried over unchanged. The test vectors therefore chain a logic operation after an arithmetic one that sets it. Leakage between the status bits and the control bits shows up on the first update after a control load, and so does a reserved bit that fails to stay fixed.

// File: rtl/flag_pkg.sv
package flag_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_LOG2  = 2'd3
  } opclass_e;

  // architected positions of each flag
  localparam int POS_CF    = 0;
  localparam int POS_PF    = 2;
  localparam int POS_AF    = 4;
  localparam int POS_ZF    = 6;
  localparam int POS_SF    = 7;
  localparam int POS_TF    = 8;
  localparam int POS_IE    = 9;
  localparam int POS_DF    = 10;
  localparam int POS_OF    = 11;
  localparam int POS_PL_LO = 12;
  localparam int POS_NT    = 14;
  localparam int POS_RF    = 16;
  localparam int POS_VM    = 17;

  localparam logic [DATA_W-1:0] FIXED_ONES = 32'h0000_0002;
  localparam logic [DATA_W-1:0] CTL_MASK   = 32'h0003_7700;
  localparam logic [DATA_W-1:0] STAT_MASK  = 32'h0000_08D5;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } stat_t;

  typedef struct packed {
    logic       vm;
    logic       rf;
    logic       nt;
    logic [1:0] pl;
    logic       dir;
    logic       ie;
    logic       trap;
  } ctl_t;

  function automatic ctl_t ctl_extract(input logic [DATA_W-1:0] w);
    ctl_t c;
    c.trap = w[POS_TF];
    c.ie   = w[POS_IE];
    c.dir  = w[POS_DF];
    c.pl   = w[POS_PL_LO+1:POS_PL_LO];
    c.nt   = w[POS_NT];
    c.rf   = w[POS_RF];
    c.vm   = w[POS_VM];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(input stat_t s, input ctl_t c);
    logic [DATA_W-1:0] w;
    w                        = FIXED_ONES;
    w[POS_CF]                = s.cry;
    w[POS_PF]                = s.par;
    w[POS_AF]                = s.aux;
    w[POS_ZF]                = s.zro;
    w[POS_SF]                = s.sgn;
    w[POS_OF]                = s.ovf;
    w[POS_TF]                = c.trap;
    w[POS_IE]                = c.ie;
    w[POS_DF]                = c.dir;
    w[POS_PL_LO+1:POS_PL_LO] = c.pl;
    w[POS_NT]                = c.nt;
    w[POS_RF]                = c.rf;
    w[POS_VM]                = c.vm;
    return w;
  endfunction

endpackage

// File: rtl/flag_lane_eval.sv
// Carry/borrow, overflow, sign and zero for one operand width.
module flag_lane_eval #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] r,
  input  logic              is_sub,
  output logic              cf,
  output logic              of,
  output logic              sf,
  output logic              zf
);
  localparam int MSB = LANE_W - 1;

  logic a_t, b_t, r_t;

  always_comb begin
    a_t = a[MSB];
    b_t = b[MSB];
    r_t = r[MSB];
    if (is_sub) begin
      cf = (~a_t & b_t) | (~(a_t ^ b_t) & r_t);
      of = (a_t ^ b_t) & (a_t ^ r_t);
    end else begin
      cf = (a_t & b_t) | ((a_t ^ b_t) & ~r_t);
      of = ~(a_t ^ b_t) & (a_t ^ r_t);
    end
    sf = r_t;
    zf = ~|r;
  end
endmodule

// File: rtl/flag_parity.sv
// Even-parity detect over the low slice of the result.
module flag_parity #(
  parameter int PAR_W = 8
) (
  input  logic [PAR_W-1:0] r_low,
  output logic             pf
);
  assign pf = ~^r_low;
endmodule

// File: rtl/flag_state_reg.sv
// Holds status and control fields separately; output word is composed from the registers.
module flag_state_reg
  import flag_pkg::*;
#(
  parameter int WORD_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_we,
  input  stat_t             stat_d,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_word,
  output logic [WORD_W-1:0] word_q
);
  stat_t stat_q;
  ctl_t  ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (stat_we) stat_q <= stat_d;
      if (ctl_we)  ctl_q  <= ctl_extract(ctl_word);
    end
  end

  assign word_q = pack_word(stat_q, ctl_q);
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import flag_pkg::*;
#(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  parameter int NIB_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] result,
  input  logic              ctl_load,
  input  logic [DATA_W-1:0] ctl_data,
  output logic [DATA_W-1:0] flags_q
);
  localparam int TOP_IDX = NUM_SIZES - 1;

  logic [NUM_SIZES-1:0] lane_cf, lane_of, lane_sf, lane_zf;
  logic                 is_sub, is_logic;
  logic [1:0]           sel_idx;
  logic                 pf_w;
  stat_t                stat_next;
  stat_t                stat_prev;

  assign is_sub   = (opclass_e'(op_class) == OPC_SUB);
  assign is_logic = op_class[1];
  assign sel_idx  = (int'(op_size) > TOP_IDX) ? 2'(TOP_IDX) : op_size;

  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_lane
    localparam int LW = BASE_W << gi;
    flag_lane_eval #(.LANE_W(LW)) u_lane (
      .a      (src_a[LW-1:0]),
      .b      (src_b[LW-1:0]),
      .r      (result[LW-1:0]),
      .is_sub (is_sub),
      .cf     (lane_cf[gi]),
      .of     (lane_of[gi]),
      .sf     (lane_sf[gi]),
      .zf     (lane_zf[gi])
    );
  end

  flag_parity #(.PAR_W(BASE_W)) u_par (
    .r_low (result[BASE_W-1:0]),
    .pf    (pf_w)
  );

  assign stat_prev.cry = flags_q[POS_CF];
  assign stat_prev.par = flags_q[POS_PF];
  assign stat_prev.aux = flags_q[POS_AF];
  assign stat_prev.zro = flags_q[POS_ZF];
  assign stat_prev.sgn = flags_q[POS_SF];
  assign stat_prev.ovf = flags_q[POS_OF];

  always_comb begin
    stat_next.par = pf_w;
    stat_next.zro = lane_zf[sel_idx];
    stat_next.sgn = lane_sf[sel_idx];
    if (is_logic) begin
      stat_next.cry = 1'b0;
      stat_next.ovf = 1'b0;
      stat_next.aux = stat_prev.aux;
    end else begin
      stat_next.cry = lane_cf[sel_idx];
      stat_next.ovf = lane_of[sel_idx];
      stat_next.aux = src_a[NIB_BIT] ^ src_b[NIB_BIT] ^ result[NIB_BIT];
    end
  end

  flag_state_reg #(.WORD_W(DATA_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .stat_we  (upd_en),
    .stat_d   (stat_next),
    .ctl_we   (ctl_load),
    .ctl_word (ctl_data),
    .word_q   (flags_q)
  );
endmodule

// File: rtl/flag_unit_checker.sv
module flag_unit_checker
  import flag_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              upd_en,
  input logic [1:0]        op_class,
  input logic              ctl_load,
  input logic [DATA_W-1:0] ctl_data,
  input logic [DATA_W-1:0] flags_q
);
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> flags_q == FIXED_ONES);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!upd_en && !ctl_load) |=> $stable(flags_q));

  a_r8_logic_flags: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_class[1]) |=>
      (!flags_q[POS_CF] && !flags_q[POS_OF] && flags_q[POS_AF] == $past(flags_q[POS_AF])));

  a_r9_ctl_write: assert property (@(posedge clk) disable iff (rst)
    ctl_load |=> (flags_q & CTL_MASK) == ($past(ctl_data) & CTL_MASK));

  a_r9_ctl_keep: assert property (@(posedge clk) disable iff (rst)
    !ctl_load |=> (flags_q & CTL_MASK) == ($past(flags_q) & CTL_MASK));

  a_r9_stat_keep: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> (flags_q & STAT_MASK) == ($past(flags_q) & STAT_MASK));

  a_r10_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~(CTL_MASK | STAT_MASK)) == FIXED_ONES);
endmodule

bind status_flag_unit flag_unit_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .upd_en   (upd_en),
  .op_class (op_class),
  .ctl_load (ctl_load),
  .ctl_data (ctl_data),
  .flags_q  (flags_q)
);

// File: tb/test_status_flag_unit.sv
module test_status_flag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic [1:0]  op_size = 2'd2;
  logic [31:0] src_a = '0, src_b = '0, result = '0;
  logic        ctl_load = 1'b0;
  logic [31:0] ctl_data = '0;
  logic [31:0] flags_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  status_flag_unit i_status_flag_unit (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_class(op_class), .op_size(op_size),
    .src_a(src_a), .src_b(src_b), .result(result),
    .ctl_load(ctl_load), .ctl_data(ctl_data), .flags_q(flags_q)
  );

  typedef struct packed {
    logic [1:0]  cls;
    logic [1:0]  sz;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  // cls: 0 add, 1 sub, 2 logic; sz: 0 byte, 1 half, 2 word
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h0000_0057}, // R3 R5 R6 R7 carry out, zero
    '{2'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h0000_0896}, // R4 signed overflow
    '{2'd0, 2'd0, 32'h1234_5680, 32'h0000_0080, 32'h1234_5700, 32'h0000_0847}, // R3 R4 R7 byte boundary
    '{2'd1, 2'd1, 32'h0000_0000, 32'h0000_0001, 32'h0000_FFFF, 32'h0000_0097}, // R3 borrow at half
    '{2'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h0000_0816}, // R4 sub overflow
    '{2'd2, 2'd2, 32'h0000_00F0, 32'h0000_000F, 32'h0000_0007, 32'h0000_0012}, // R8 aux held at 1
    '{2'd0, 2'd1, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0006}, // R6 no carry
    '{2'd2, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0180, 32'h0000_0082}, // R7 byte sign
    '{2'd2, 2'd1, 32'h0000_0000, 32'h0000_0000, 32'hABCD_0000, 32'h0000_0046}, // R7 upper bits ignored
    '{2'd0, 2'd0, 32'h0000_000F, 32'h0000_0001, 32'h0000_0010, 32'h0000_0012}, // R5 nibble carry
    '{2'd1, 2'd0, 32'h0000_0000, 32'h0000_0080, 32'h0000_0080, 32'h0000_0883}  // R3 R4 byte borrow
  };

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (flags_q !== exp) begin
      errors++;
      $display("FAIL %s: flags_q=%08h expected=%08h", tag, flags_q, exp);
    end
  endtask

  task automatic drive_op(input logic [1:0] c, input logic [1:0] s,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
    op_class = c; op_size = s; src_a = a; src_b = b; result = r;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", 32'h0000_0002);
    rst = 1'b0;

    // R2: inputs change but no strobe
    drive_op(2'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0);
    @(negedge clk);
    @(negedge clk);
    check("R2 idle hold", 32'h0000_0002);

    for (int i = 0; i < NV; i++) begin
      drive_op(VECS[i].cls, VECS[i].sz, VECS[i].a, VECS[i].b, VECS[i].r);
      upd_en = 1'b1;
      @(negedge clk);
      check($sformatf("R3-vector %0d", i), VECS[i].exp);
    end
    upd_en = 1'b0;

    // R9 R10: control load of all ones, status untouched, reserved fixed
    ctl_data = 32'hFFFF_FFFF;
    ctl_load = 1'b1;
    drive_op(2'd0, 2'd2, 32'h1, 32'h1, 32'h0);
    @(negedge clk);
    ctl_load = 1'b0;
    check("R9 R10 control load", 32'h0003_7F83);

    // R9: arithmetic update keeps control bits
    drive_op(2'd0, 2'd2, 32'h1, 32'h1, 32'h2);
    upd_en = 1'b1;
    @(negedge clk);
    check("R9 update keeps control", 32'h0003_7702);

    // R9 R8: simultaneous control clear and logic update
    ctl_data = 32'h0;
    ctl_load = 1'b1;
    drive_op(2'd2, 2'd2, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    upd_en = 1'b0;
    ctl_load = 1'b0;
    check("R9 R8 simultaneous", 32'h0000_0046);

    // R1: reset mid-run
    ctl_data = 32'hFFFF_FFFF;
    ctl_load = 1'b1;
    @(negedge clk);
    ctl_load = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after use", 32'h0000_0002);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule